// File: doc/BRIEF.md
# Integer Execute Stage with Condition Flags

This block is the execute step of a small 64-bit integer pipeline. Each cycle in which `valid_i` is high it takes one fixed-width 32-bit instruction word together with two 64-bit operand values that an upstream register file read has already produced. `op_a_i` carries the first source register value and `op_b_i` carries the second. The block decodes a compact integer subset:

- move of a 16-bit immediate into a cleared register, at one of four halfword positions;
- add and subtract in register form and in 12-bit immediate form, each with or without a condition-flag update;
- bitwise AND, OR and exclusive-OR in register form.

One cycle later the block presents the destination index, the 64-bit result and a write strobe for the register file. A word outside the subset instead raises a one-cycle illegal pulse.

A persistent 4-bit condition register holds negative, zero, carry and overflow. Only the flag-setting add and subtract variants change it. Every other instruction, every illegal word and every idle cycle leaves it unchanged. Shifted-register modifiers, 32-bit operand size, branches and memory access are not decoded and count as illegal.

Top module: `alu_exec`

## Requirements
- R1: After reset `wr_en_o`, `illegal_o`, `rd_o`, `result_o` and `flags_o` are all zero.
- R2: A word with bits 31:23 = 110100101 is a move: the result is imm16 (bits 20:5) shifted left by 16 times hw (bits 22:21), and the destination is bits 4:0. The word 0xD2800020 writes 1 to register 0.
- R3: A word with bit 31 = 1 and bits 28:23 = 100010 is an immediate add/subtract. Bit 30 selects subtract (1) or add (0). Bit 29 selects the flag update. imm12 sits in bits 21:10 and is shifted left by 12 when bit 22 is 1. The result is `op_a_i` plus or minus that immediate. Subtracting 10 with source index 5 and destination 4 is one of the cases.
- R4: A word with bit 31 = 1, bits 28:21 = 01011000 and bits 15:10 = 0 is a register add/subtract, with bits 30 and 29 as in R3. The result is `op_a_i` plus or minus `op_b_i`. The word 0x8B030041 adds into destination 1.
- R5: A word with bit 31 = 1, bits 28:21 = 01010000 and bits 15:10 = 0 is a register logical operation. Bits 30:29 select the operation: 00 for AND, 01 for OR, 10 for XOR. The words 0x8A0800E6, 0xAA0B0149 and 0xCA0E01AC write destinations 6, 9 and 12.
- R6: The outputs are registered. `wr_en_o`, `rd_o` and `result_o` reflect a legal valid word exactly one cycle after it is presented. `wr_en_o` is low in any cycle that does not follow a valid legal word.
- R7: `flags_o[3]` is N and equals result bit 63. `flags_o[2]` is Z and is set when the result is zero. `flags_o[1]` is C, the carry out of an add. `flags_o[0]` is V, the signed overflow. These are status-word bits 31 down to 28.
- R8: For a subtract, C is 1 exactly when `op_a_i` is greater than or equal to the subtrahend, both taken as unsigned values.
- R9: `flags_o` changes only after a valid add/subtract word whose bit 29 is 1. All other words leave it unchanged.
- R10: Any valid word not covered by R2 to R5 is illegal. This includes bit 31 = 0, bits 30:29 = 11 in the logical form, and nonzero bits 15:10. An illegal word raises `illegal_o` for one cycle, keeps `wr_en_o` low, and leaves `flags_o`, `rd_o` and `result_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word and operands are present |
| instr_i | input | 32 | Instruction word |
| op_a_i | input | 64 | First source register value |
| op_b_i | input | 64 | Second source register value |
| wr_en_o | output | 1 | Register file write strobe |
| rd_o | output | 5 | Destination register index |
| result_o | output | 64 | Result value |
| flags_o | output | 4 | Condition flags N, Z, C, V (bit 3 down to bit 0) |
| illegal_o | output | 1 | Unsupported word seen, one-cycle pulse |

## Verification
The condition register is the only state that outlives one instruction. A wrong update shows at `flags_o` on the cycle after the offending word, and the bench compares the flags after every single operation, flag-setting or not. A stray flag write from a logical, move or illegal word is therefore caught at once, instead of surfacing later. Decode slips show on the same cycle: `rd_o`, `result_o`, `wr_en_o` or `illegal_o` no longer match the value computed from the word fields. The operand sweeps push values across the sign, carry and zero boundaries, so a swapped carry sense or a wrong overflow term appears within the first few dozen operations.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned IW   = 32;
  localparam int unsigned RIDX = 5;

  typedef enum logic [2:0] {
    OP_MOV = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_AND = 3'd3,
    OP_ORR = 3'd4,
    OP_EOR = 3'd5,
    OP_ILL = 3'd6
  } op_e;

  typedef struct packed {
    op_e             op;
    logic            use_imm;
    logic            set_flags;
    logic [RIDX-1:0] rd;
    logic [15:0]     imm16;
    logic [1:0]      hw;
    logic [11:0]     imm12;
    logic            imm_sh;
  } dec_t;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [IW-1:0] instr_i,
  output dec_t          dec_o,
  output logic          legal_o
);
  logic is_mov, is_addi, is_addr, is_log;

  always_comb begin
    is_mov  = (instr_i[31:23] == 9'b110100101);
    is_addi = instr_i[31] && (instr_i[28:23] == 6'b100010);
    is_addr = instr_i[31] && (instr_i[28:21] == 8'b01011000) && (instr_i[15:10] == 6'd0);
    is_log  = instr_i[31] && (instr_i[28:21] == 8'b01010000) && (instr_i[15:10] == 6'd0)
              && (instr_i[30:29] != 2'b11);
  end

  always_comb begin
    dec_o.rd        = instr_i[4:0];
    dec_o.imm16     = instr_i[20:5];
    dec_o.hw        = instr_i[22:21];
    dec_o.imm12     = instr_i[21:10];
    dec_o.imm_sh    = instr_i[22];
    dec_o.use_imm   = is_addi;
    dec_o.set_flags = (is_addi || is_addr) && instr_i[29];
    dec_o.op        = OP_ILL;
    if (is_mov) dec_o.op = OP_MOV;
    else if (is_addi || is_addr) dec_o.op = instr_i[30] ? OP_SUB : OP_ADD;
    else if (is_log) begin
      unique case (instr_i[30:29])
        2'b00:   dec_o.op = OP_AND;
        2'b01:   dec_o.op = OP_ORR;
        default: dec_o.op = OP_EOR;
      endcase
    end
    legal_o = (dec_o.op != OP_ILL);
  end

  // the instruction classes must never overlap (R10)
  always_comb begin
    p_class_onehot_r10: assert ($onehot0({is_mov, is_addi, is_addr, is_log}));
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o,
  output logic [3:0]      nzcv_o
);
  logic [XLEN-1:0] b_eff;
  logic            cout;

  always_comb begin
    b_eff         = sub_i ? ~b_i : b_i;
    {cout, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub_i};
    nzcv_o[3]     = sum_o[XLEN-1];
    nzcv_o[2]     = (sum_o == '0);
    nzcv_o[1]     = cout;
    nzcv_o[0]     = (a_i[XLEN-1] == b_eff[XLEN-1]) && (sum_o[XLEN-1] != a_i[XLEN-1]);
  end

  always_comb begin
    if (sub_i) p_sub_carry_r8: assert (cout == (a_i >= b_i));
    else       p_add_carry_r7: assert (cout == (sum_o < a_i));
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [1:0]      sel_i,
  output logic [XLEN-1:0] y_o
);
  always_comb begin
    unique case (sel_i)
      2'd0:    y_o = a_i & b_i;
      2'd1:    y_o = a_i | b_i;
      default: y_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] op_a_i,
  input  logic [XLEN-1:0] op_b_i,
  output logic            wr_en_o,
  output logic [4:0]      rd_o,
  output logic [XLEN-1:0] result_o,
  output logic [3:0]      flags_o,
  output logic            illegal_o
);
  dec_t            dec;
  logic            legal;
  logic [XLEN-1:0] imm_ext, b_sel, mov_val, sum, logic_y, res_d;
  logic [3:0]      nzcv;
  logic [1:0]      log_sel;
  logic            accept, upd_flags;

  alu_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec),
    .legal_o (legal)
  );

  always_comb begin
    imm_ext = dec.imm_sh ? XLEN'({dec.imm12, 12'b0}) : XLEN'(dec.imm12);
    b_sel   = dec.use_imm ? imm_ext : op_b_i;
    mov_val = XLEN'(dec.imm16) << {dec.hw, 4'b0000};
    log_sel = (dec.op == OP_AND) ? 2'd0 : (dec.op == OP_ORR) ? 2'd1 : 2'd2;
  end

  alu_addsub #(.XLEN(XLEN)) u_add (
    .a_i    (op_a_i),
    .b_i    (b_sel),
    .sub_i  (dec.op == OP_SUB),
    .sum_o  (sum),
    .nzcv_o (nzcv)
  );

  alu_bitwise #(.XLEN(XLEN)) u_log (
    .a_i   (op_a_i),
    .b_i   (op_b_i),
    .sel_i (log_sel),
    .y_o   (logic_y)
  );

  always_comb begin
    unique case (dec.op)
      OP_MOV:         res_d = mov_val;
      OP_ADD, OP_SUB: res_d = sum;
      default:        res_d = logic_y;
    endcase
    accept    = valid_i && legal;
    upd_flags = accept && dec.set_flags;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
      rd_o      <= '0;
      result_o  <= '0;
      flags_o   <= '0;
    end else begin
      wr_en_o   <= accept;
      illegal_o <= valid_i && !legal;
      if (accept) begin
        rd_o     <= dec.rd;
        result_o <= res_d;
      end
      if (upd_flags) flags_o <= nzcv;
    end
  end

  p_wr_after_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(valid_i));
  p_pulse_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && illegal_o));
  p_illegal_after_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(valid_i));
  p_flags_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_flags |=> $stable(flags_o));
endmodule

// File: tb/tb_alu_exec.sv
module tb_alu_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] opa = '0, opb = '0;
  logic        wr_en, illegal;
  logic [4:0]  rd;
  logic [63:0] result;
  logic [3:0]  flags;

  int total = 0;
  int bad = 0;
  logic [3:0]  m_flags = 4'h0;
  logic [63:0] m_res = '0;
  logic [4:0]  m_rd = '0;

  always #5 clk = ~clk;

  alu_exec dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .op_a_i(opa), .op_b_i(opb), .wr_en_o(wr_en), .rd_o(rd),
    .result_o(result), .flags_o(flags), .illegal_o(illegal)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] w_mov(input logic [1:0] hw, input logic [15:0] imm, input logic [4:0] d);
    return {9'b110100101, hw, imm, d};
  endfunction
  function automatic logic [31:0] w_imm(input logic sub, input logic s, input logic sh,
                                        input logic [11:0] imm, input logic [4:0] n, input logic [4:0] d);
    return {1'b1, sub, s, 6'b100010, sh, imm, n, d};
  endfunction
  function automatic logic [31:0] w_reg(input logic sub, input logic s, input logic [4:0] m,
                                        input logic [4:0] n, input logic [4:0] d);
    return {1'b1, sub, s, 8'b01011000, m, 6'd0, n, d};
  endfunction
  function automatic logic [31:0] w_log(input logic [1:0] opc, input logic [4:0] m,
                                        input logic [4:0] n, input logic [4:0] d);
    return {1'b1, opc, 8'b01010000, m, 6'd0, n, d};
  endfunction

  // expected flags: N, Z, C, V from unsigned/signed reasoning
  function automatic logic [3:0] exp_nzcv(input logic [63:0] a, input logic [63:0] b,
                                          input logic sub, input logic [63:0] r);
    logic c, v;
    if (sub) begin
      c = (a >= b);
      v = (a[63] != b[63]) && (r[63] != a[63]);
    end else begin
      c = (r < a);
      v = (a[63] == b[63]) && (r[63] != a[63]);
    end
    return {r[63], r == 64'd0, c, v};
  endfunction

  // present one word, check outputs one cycle later
  task automatic run(input string req, input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                     input logic legal, input logic [63:0] exp_r, input logic setf, input logic [3:0] nf);
    @(negedge clk);
    instr = w; opa = a; opb = b; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    if (legal) begin
      m_rd = w[4:0];
      m_res = exp_r;
      if (setf) m_flags = nf;
    end
    chk({req, " R6 wr_en"}, 64'(wr_en), 64'(legal));
    chk({req, " R10 illegal"}, 64'(illegal), 64'(!legal));
    chk({req, " rd"}, 64'(rd), 64'(m_rd));
    chk({req, " result"}, result, m_res);
    chk({req, " R9 flags"}, 64'(flags), 64'(m_flags));
  endtask

  task automatic arith(input string req, input logic [31:0] w, input logic [63:0] a, input logic [63:0] bop,
                       input logic [63:0] beff, input logic sub, input logic s);
    logic [63:0] r;
    r = sub ? a - beff : a + beff;
    run(req, w, a, bop, 1'b1, r, s, exp_nzcv(a, beff, sub, r));
  endtask

  logic [63:0] pat [8];
  logic [11:0] imms [6];

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    pat[0] = 64'h0;                 pat[1] = 64'h1;
    pat[2] = 64'hFFFF_FFFF_FFFF_FFFF; pat[3] = 64'h8000_0000_0000_0000;
    pat[4] = 64'h7FFF_FFFF_FFFF_FFFF; pat[5] = 64'h0000_0000_0000_000A;
    pat[6] = 64'h1234_5678_9ABC_DEF0; pat[7] = 64'hFFFF_FFFF_FFFF_F000;
    imms[0] = 12'd0; imms[1] = 12'd1; imms[2] = 12'd10;
    imms[3] = 12'hFFF; imms[4] = 12'h800; imms[5] = 12'h123;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 wr_en", 64'(wr_en), 0);
    chk("R1 illegal", 64'(illegal), 0);
    chk("R1 rd", 64'(rd), 0);
    chk("R1 result", result, 0);
    chk("R1 flags", 64'(flags), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 idle wr_en", 64'(wr_en), 0);

    // fixed words
    run("R2 mov 1 to x0", 32'hD280_0020, 64'h55, 64'h66, 1'b1, 64'd1, 1'b0, 4'h0);
    chk("R2 rd0", 64'(rd), 0);
    arith("R4 add x1", 32'h8B03_0041, 64'd7, 64'd9, 64'd9, 1'b0, 1'b0);
    chk("R4 rd1", 64'(rd), 1);
    arith("R3 sub 10 x4", w_imm(1'b1, 1'b0, 1'b0, 12'd10, 5'd5, 5'd4), 64'd100, 64'd0, 64'd10, 1'b1, 1'b0);
    chk("R3 rd4 value", result, 64'd90);
    run("R5 and", 32'h8A08_00E6, pat[6], pat[7], 1'b1, pat[6] & pat[7], 1'b0, 4'h0);
    chk("R5 rd6", 64'(rd), 6);
    run("R5 orr", 32'hAA0B_0149, pat[6], pat[3], 1'b1, pat[6] | pat[3], 1'b0, 4'h0);
    chk("R5 rd9", 64'(rd), 9);
    run("R5 eor", 32'hCA0E_01AC, pat[6], pat[2], 1'b1, pat[6] ^ pat[2], 1'b0, 4'h0);
    chk("R5 rd12", 64'(rd), 12);

    // R2 move sweep over halfword positions
    for (int hw = 0; hw < 4; hw++)
      for (int k = 0; k < 4; k++) begin
        logic [15:0] im;
        im = (k == 0) ? 16'h0 : (k == 1) ? 16'h1 : (k == 2) ? 16'hFFFF : 16'hA5C3;
        run("R2 mov", w_mov(2'(hw), im, 5'(hw * 4 + k)), pat[2], pat[6], 1'b1,
            64'(im) << (16 * hw), 1'b0, 4'h0);
      end

    // R4 R7 R8 R9 register add/sub sweep
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          arith(op[1] ? "R4 R7 R8 R9 regS" : "R4 reg",
                w_reg(op[0], op[1], 5'(j), 5'(i), 5'((i * 7 + j) % 32)),
                pat[i], pat[j], pat[j], op[0], op[1]);

    // R3 R7 R8 immediate sweep
    for (int op = 0; op < 4; op++)
      for (int sh = 0; sh < 2; sh++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 6; j++) begin
            logic [63:0] be;
            be = sh[0] ? 64'(imms[j]) << 12 : 64'(imms[j]);
            arith(op[1] ? "R3 R7 R8 immS" : "R3 imm",
                  w_imm(op[0], op[1], sh[0], imms[j], 5'(i), 5'((i + j * 3) % 32)),
                  pat[i], pat[(i + 3) % 8], be, op[0], op[1]);
          end

    // set known flags, then R5 logical sweep must not disturb them (R9)
    arith("R7 R8 setup", w_reg(1'b1, 1'b1, 5'd1, 5'd2, 5'd3), 64'd5, 64'd5, 64'd5, 1'b1, 1'b1);
    chk("R7 zero+carry", 64'(flags), 64'h6);
    for (int opc = 0; opc < 3; opc++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          logic [63:0] e;
          e = (opc == 0) ? (pat[i] & pat[j]) : (opc == 1) ? (pat[i] | pat[j]) : (pat[i] ^ pat[j]);
          run("R5 R9 logic", w_log(2'(opc), 5'(j), 5'(i), 5'((i + j) % 32)), pat[i], pat[j], 1'b1,
              e, 1'b0, 4'h0);
        end

    // R10 illegal words: prior rd/result/flags must hold
    arith("R7 setup neg", w_reg(1'b1, 1'b1, 5'd1, 5'd2, 5'd17), 64'd1, 64'd2, 64'd2, 1'b1, 1'b1);
    chk("R7 N set", 64'(flags), 64'h8);
    run("R10 size0 add", 32'h0B03_0041, 64'd1, 64'd1, 1'b0, 0, 1'b0, 4'h0);
    run("R10 ands", w_log(2'b11, 5'd1, 5'd2, 5'd3), 64'd1, 64'd1, 1'b0, 0, 1'b0, 4'h0);
    run("R10 shifted reg", 32'hEB03_0441, 64'd1, 64'd1, 1'b0, 0, 1'b0, 4'h0);
    run("R10 zero word", 32'h0000_0000, 64'd1, 64'd1, 1'b0, 0, 1'b0, 4'h0);
    run("R10 ones word", 32'hFFFF_FFFF, 64'd1, 64'd1, 1'b0, 0, 1'b0, 4'h0);
    run("R10 extended reg", 32'hAB23_0041, 64'd1, 64'd1, 1'b0, 0, 1'b0, 4'h0);
    @(negedge clk);
    chk("R10 pulse one cycle", 64'(illegal), 0);
    chk("R6 idle after", 64'(wr_en), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule